// File: doc/BRIEF.md
# CPU Register Write Spy

This block sits on a host CPU bus next to a video controller and an audio/IO unit, both of whose registers are mostly write-only. It watches every bus cycle. When a cycle hits one of the eight video registers, including any of their mirrors, or one of the thirty-two audio/IO registers, it stores the byte in a shadow slot. Software can then recover the last value written to any of those registers.

Two video registers (scroll and address, offsets 5 and 6) each take a pair of byte writes. Both share one first/second toggle. The spy models that toggle, so the first and second bytes land in separate slots. A read of the video status register (offset 2) sends the toggle back to the first-write state. The two audio/IO registers at 0x4016 and 0x4017 mean different things on read and on write. For those two, the byte seen on a read goes into its own slot.

Software picks a slot by writing its 6-bit index to a select address. It then reads the byte back at a read-back address. Both addresses sit outside the snooped windows.

A three-state bus tracker follows the bus clock strobe through three states:
- IDLE: the strobe is low.
- ACTIVE: the strobe is high, and the tracker keeps the latest address, data and direction.
- COMMIT: a one-cycle state after the strobe falls, in which the held access is applied.

The tracker moves IDLE→ACTIVE when the strobe rises. It moves ACTIVE→COMMIT when the strobe falls. From COMMIT it moves to ACTIVE if the strobe is already high again, and to IDLE otherwise.

A two-state toggle machine has the states FIRST and SECOND. It moves FIRST↔SECOND on each write to offset 5 or 6. It moves from either state to FIRST on a status read.

Top module: `cpu_reg_spy`

## Requirements
- R1: After reset every shadow slot reads 0x00, the select index is 0, and the toggle is in the first-write state.
- R2: A write whose address matches 001x_xxxx_xxxx_xyyy stores the data in slot yyy (0..7), whatever the middle bits are. The exception is a second-byte write to offset 5 or 6 (see R4).
- R3: A write whose address matches 0100_0000_000y_yyyy stores the data in slot 32 + yyyyy (32..63).
- R4: Writes to video offset 5 or 6 go to slot 5 or 6 when the shared toggle is in the first-write state. They go to slot 8 (offset 5) or slot 9 (offset 6) when it is in the second-write state. Every such write flips the toggle.
- R5: A read of any video-window address with low bits 010 returns the toggle to the first-write state. It does not change any slot.
- R6: A read of 0x4016 stores the bus byte in slot 10, and a read of 0x4017 stores it in slot 11. Writes to these two addresses use slots 54 and 55, as R3 gives.
- R7: A write to the select address (default 0x5800) loads bits 5..0 of the data as the slot index. Reading the read-back address (default 0x5801) presents that slot on rb_data, and rb_drive is high while the read is in progress.
- R8: No slot changes for any of these accesses:
  - an access outside both windows;
  - a read in the video window;
  - a read in the audio/IO window other than 0x4016 or 0x4017.
- R9: Writes to the select address and reads of the read-back address leave the toggle unchanged, and are not shadowed.
- R10: The stored byte is the value on the data bus at the last clock sample before the strobe falls. Earlier values in the same cycle are not stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the bus strobe |
| rst_n | input | 1 | Active-low synchronous reset |
| m2 | input | 1 | Bus cycle strobe; the access completes on its falling edge |
| cpu_rw | input | 1 | Bus direction: 1 = read, 0 = write |
| cpu_addr | input | 16 | Bus address |
| cpu_data | input | 8 | Bus data as seen by the spy |
| rb_data | output | 8 | Byte held in the selected shadow slot |
| rb_drive | output | 1 | High while the CPU reads the read-back address |

## Verification
Plain writes are tried at base and mirrored video addresses and across the audio/IO window, to show that decoding ignores the mirror bits. Alternating and interleaved writes to the two double-write registers, with status reads placed between them, separate a toggle per register from the shared toggle, and show whether the status read clears it. Accesses just outside each window, reads into the windows, and select-register traffic between paired writes confirm that none of them touch the slots or the toggle. A bus cycle whose data changes while the strobe is high shows which sample gets stored.

// File: rtl/spy_pkg.sv
package spy_pkg;
    localparam int ADDR_W  = 16;
    localparam int DATA_W  = 8;
    localparam int SLOT_W  = 6;
    localparam int NSLOT   = 1 << SLOT_W;
    localparam int VID_REGS_W = 3;
    localparam int AUD_REGS_W = 5;

    localparam logic [SLOT_W-1:0] SLOT_SCROLL_HI = SLOT_W'(8);
    localparam logic [SLOT_W-1:0] SLOT_ADDR_HI   = SLOT_W'(9);
    localparam logic [SLOT_W-1:0] SLOT_PORT_RD0  = SLOT_W'(10);
    localparam logic [SLOT_W-1:0] SLOT_AUD_BASE  = SLOT_W'(32);

    localparam logic [VID_REGS_W-1:0] VID_STATUS = 3'd2;
    localparam logic [VID_REGS_W-1:0] VID_SCROLL = 3'd5;
    localparam logic [VID_REGS_W-1:0] VID_ADDR   = 3'd6;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              rd;
    } access_t;

    typedef enum logic [1:0] {
        BUS_IDLE   = 2'd0,
        BUS_ACTIVE = 2'd1,
        BUS_COMMIT = 2'd2
    } bus_state_t;

    typedef enum logic {
        TGL_FIRST  = 1'b0,
        TGL_SECOND = 1'b1
    } tgl_state_t;

    function automatic logic in_video(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:ADDR_W-3] == 3'b001;
    endfunction

    function automatic logic in_audio(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:AUD_REGS_W] == 11'b0100_0000_000;
    endfunction
endpackage

// File: rtl/spy_bus_fsm.sv
module spy_bus_fsm
    import spy_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              m2,
    input  logic              cpu_rw,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_data,
    output logic              cmt_valid,
    output access_t           cmt_acc
);
    bus_state_t state, state_nx;
    logic       m2_s;
    access_t    smp, held;

    // input sampling stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m2_s <= 1'b0;
            smp  <= '0;
        end else begin
            m2_s <= m2;
            smp  <= '{addr: cpu_addr, data: cpu_data, rd: cpu_rw};
        end
    end

    // latest sample while the strobe is high
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held <= '0;
        end else if (m2_s) begin
            held <= smp;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            BUS_IDLE:   state_nx = m2_s ? BUS_ACTIVE : BUS_IDLE;
            BUS_ACTIVE: state_nx = m2_s ? BUS_ACTIVE : BUS_COMMIT;
            BUS_COMMIT: state_nx = m2_s ? BUS_ACTIVE : BUS_IDLE;
            default:    state_nx = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= BUS_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        cmt_valid = (state == BUS_COMMIT);
        cmt_acc   = held;
    end
endmodule

// File: rtl/spy_toggle.sv
module spy_toggle
    import spy_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic flip,
    input  logic clear,
    output logic second
);
    tgl_state_t state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            TGL_FIRST:  state_nx = (flip && !clear) ? TGL_SECOND : TGL_FIRST;
            TGL_SECOND: state_nx = (flip || clear) ? TGL_FIRST : TGL_SECOND;
            default:    state_nx = TGL_FIRST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= TGL_FIRST;
        else        state <= state_nx;
    end

    always_comb second = (state == TGL_SECOND);
endmodule

// File: rtl/spy_decode.sv
module spy_decode
    import spy_pkg::*;
#(
    parameter logic [ADDR_W-1:0] SEL_ADDR = 16'h5800
) (
    input  logic              vld,
    input  access_t           acc,
    input  logic              tgl_second,
    output logic              slot_we,
    output logic [SLOT_W-1:0] slot_idx,
    output logic              tgl_flip,
    output logic              tgl_clear,
    output logic              sel_we
);
    logic [VID_REGS_W-1:0] vreg;
    logic [AUD_REGS_W-1:0] areg;
    logic                  vid, aud;

    always_comb begin
        vreg      = acc.addr[VID_REGS_W-1:0];
        areg      = acc.addr[AUD_REGS_W-1:0];
        vid       = in_video(acc.addr);
        aud       = in_audio(acc.addr);
        slot_we   = 1'b0;
        slot_idx  = '0;
        tgl_flip  = 1'b0;
        tgl_clear = 1'b0;
        sel_we    = vld && !acc.rd && (acc.addr == SEL_ADDR);
        if (vld && vid && !acc.rd) begin
            slot_we = 1'b1;
            if (vreg == VID_SCROLL || vreg == VID_ADDR) begin
                tgl_flip = 1'b1;
                if (tgl_second)
                    slot_idx = (vreg == VID_SCROLL) ? SLOT_SCROLL_HI : SLOT_ADDR_HI;
                else
                    slot_idx = SLOT_W'(vreg);
            end else begin
                slot_idx = SLOT_W'(vreg);
            end
        end else if (vld && vid && acc.rd) begin
            tgl_clear = (vreg == VID_STATUS);
        end else if (vld && aud && !acc.rd) begin
            slot_we  = 1'b1;
            slot_idx = SLOT_AUD_BASE | SLOT_W'(areg);
        end else if (vld && aud && acc.rd && areg[AUD_REGS_W-1:1] == 4'b1011) begin
            slot_we  = 1'b1;
            slot_idx = SLOT_PORT_RD0 | SLOT_W'(areg[0]);
        end
    end
endmodule

// File: rtl/spy_shadow.sv
module spy_shadow
    import spy_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [SLOT_W-1:0] widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [SLOT_W-1:0] ridx,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [NSLOT];

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem[g] <= '0;
            else if (we && widx == SLOT_W'(g))
                mem[g] <= wdata;
        end
    end

    assign rdata = mem[ridx];
endmodule

// File: rtl/cpu_reg_spy.sv
module cpu_reg_spy
    import spy_pkg::*;
#(
    parameter logic [ADDR_W-1:0] SEL_ADDR = 16'h5800,
    parameter logic [ADDR_W-1:0] RB_ADDR  = 16'h5801
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              m2,
    input  logic              cpu_rw,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_data,
    output logic [DATA_W-1:0] rb_data,
    output logic              rb_drive
);
    logic              cmt_valid;
    access_t           cmt_acc;
    logic              tgl_second, tgl_flip, tgl_clear;
    logic              slot_we, sel_we;
    logic [SLOT_W-1:0] slot_idx, sel_q;

    spy_bus_fsm i_bus (
        .clk(clk), .rst_n(rst_n), .m2(m2), .cpu_rw(cpu_rw),
        .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .cmt_valid(cmt_valid), .cmt_acc(cmt_acc)
    );

    spy_decode #(.SEL_ADDR(SEL_ADDR)) i_dec (
        .vld(cmt_valid), .acc(cmt_acc), .tgl_second(tgl_second),
        .slot_we(slot_we), .slot_idx(slot_idx),
        .tgl_flip(tgl_flip), .tgl_clear(tgl_clear), .sel_we(sel_we)
    );

    spy_toggle i_tgl (
        .clk(clk), .rst_n(rst_n), .flip(tgl_flip), .clear(tgl_clear),
        .second(tgl_second)
    );

    spy_shadow i_mem (
        .clk(clk), .rst_n(rst_n), .we(slot_we), .widx(slot_idx),
        .wdata(cmt_acc.data), .ridx(sel_q), .rdata(rb_data)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)      sel_q <= '0;
        else if (sel_we) sel_q <= cmt_acc.data[SLOT_W-1:0];
    end

    assign rb_drive = m2 && cpu_rw && (cpu_addr == RB_ADDR);
endmodule

// File: rtl/cpu_reg_spy_chk.sv
module cpu_reg_spy_chk
    import spy_pkg::*;
#(
    parameter logic [ADDR_W-1:0] SEL_ADDR = 16'h5800
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmt_valid,
    input access_t           cmt_acc,
    input logic              tgl_second,
    input logic              slot_we,
    input logic [SLOT_W-1:0] slot_idx
);
    logic vw, aw, pair;
    assign vw   = in_video(cmt_acc.addr);
    assign aw   = in_audio(cmt_acc.addr);
    assign pair = cmt_acc.addr[2:0] == VID_SCROLL || cmt_acc.addr[2:0] == VID_ADDR;

    a_r4_toggle_flips: assert property (@(posedge clk) disable iff (!rst_n)
        (cmt_valid && vw && !cmt_acc.rd && pair) |=> (tgl_second != $past(tgl_second)));

    a_r5_status_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (cmt_valid && vw && cmt_acc.rd && cmt_acc.addr[2:0] == VID_STATUS) |=> !tgl_second);

    a_r9_select_keeps_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (cmt_valid && cmt_acc.addr == SEL_ADDR) |=> $stable(tgl_second));

    a_r8_outside_no_store: assert property (@(posedge clk) disable iff (!rst_n)
        (cmt_valid && !vw && !aw) |-> !slot_we);

    a_r6_read_side_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (cmt_valid && cmt_acc.rd && cmt_acc.addr == 16'h4016) |-> (slot_we && slot_idx == SLOT_PORT_RD0));

    a_r10_single_commit: assert property (@(posedge clk) disable iff (!rst_n)
        cmt_valid |=> !cmt_valid);
endmodule

bind cpu_reg_spy cpu_reg_spy_chk #(.SEL_ADDR(SEL_ADDR)) i_chk (
    .clk(clk), .rst_n(rst_n), .cmt_valid(cmt_valid), .cmt_acc(cmt_acc),
    .tgl_second(tgl_second), .slot_we(slot_we), .slot_idx(slot_idx)
);

// File: tb/test_cpu_reg_spy.sv
module test_cpu_reg_spy;
    localparam logic [15:0] SEL = 16'h5800;
    localparam logic [15:0] RB  = 16'h5801;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m2 = 1'b0;
    logic        cpu_rw = 1'b1;
    logic [15:0] cpu_addr = 16'h0000;
    logic [7:0]  cpu_data = 8'h00;
    logic [7:0]  rb_data;
    logic        rb_drive;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0] val;
        int         idx;
        string      req;
    } exp_t;
    exp_t q[$];

    logic [7:0] mdl [64];
    bit         mtgl = 1'b0;

    always #4 clk = ~clk;

    cpu_reg_spy i_cpu_reg_spy (
        .clk(clk), .rst_n(rst_n), .m2(m2), .cpu_rw(cpu_rw),
        .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .rb_data(rb_data), .rb_drive(rb_drive)
    );

    // expected effect of one access, from the requirements
    task automatic model(input logic [15:0] a, input bit r, input logic [7:0] d);
        if (a[15:13] == 3'b001) begin
            if (!r) begin
                if (a[2:0] == 3'd5 || a[2:0] == 3'd6) begin
                    mdl[mtgl ? (a[2:0] == 3'd5 ? 8 : 9) : int'(a[2:0])] = d;
                    mtgl = !mtgl;
                end else begin
                    mdl[int'(a[2:0])] = d;
                end
            end else if (a[2:0] == 3'd2) begin
                mtgl = 1'b0;
            end
        end else if (a[15:5] == 11'b0100_0000_000) begin
            if (!r) mdl[32 + int'(a[4:0])] = d;
            else if (a[4:0] == 5'h16) mdl[10] = d;
            else if (a[4:0] == 5'h17) mdl[11] = d;
        end
    endtask

    task automatic bus(input logic [15:0] a, input bit r, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_rw = r; cpu_data = d; m2 = 1'b1;
        repeat (4) @(negedge clk);
        m2 = 1'b0;
        repeat (5) @(negedge clk);
        model(a, r, d);
    endtask

    // R10: data changes while the strobe is high
    task automatic bus_late(input logic [15:0] a, input logic [7:0] d0, input logic [7:0] d1);
        @(negedge clk);
        cpu_addr = a; cpu_rw = 1'b0; cpu_data = d0; m2 = 1'b1;
        repeat (2) @(negedge clk);
        cpu_data = d1;
        repeat (2) @(negedge clk);
        m2 = 1'b0;
        repeat (5) @(negedge clk);
        model(a, 1'b0, d1);
    endtask

    // driver: select slot, queue expected byte, read it back
    task automatic chk(input int idx, input string req);
        exp_t e;
        bus(SEL, 1'b0, 8'(idx));
        e.val = mdl[idx]; e.idx = idx; e.req = req;
        q.push_back(e);
        bus(RB, 1'b1, 8'h00);
    endtask

    // monitor: compares each read-back against the queue
    initial begin
        forever begin
            exp_t e;
            wait (q.size() > 0);
            @(posedge rb_drive);
            #3;
            e = q.pop_front();
            nchk++;
            if (rb_data !== e.val || rb_drive !== 1'b1) begin
                nfail++;
                $display("FAIL %s slot %0d: got %02h drive %b, expected %02h drive 1",
                         e.req, e.idx, rb_data, rb_drive, e.val);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) mdl[i] = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        nchk++;
        if (rb_data !== 8'h00 || rb_drive !== 1'b0) begin
            nfail++;
            $display("FAIL R1 reset: got %02h/%b, expected 00/0", rb_data, rb_drive);
        end
        chk(5, "R1"); chk(54, "R1"); chk(10, "R1");

        // R2: base and mirrored video writes
        bus(16'h2000, 1'b0, 8'h80);
        bus(16'h3FF9, 1'b0, 8'h1E);
        bus(16'h2A0F, 1'b0, 8'h77);
        chk(0, "R2"); chk(1, "R2"); chk(7, "R2");

        // R3: audio/IO window edges
        bus(16'h4000, 1'b0, 8'h3F);
        bus(16'h4015, 1'b0, 8'h0F);
        bus(16'h401F, 1'b0, 8'hC3);
        chk(32, "R3"); chk(53, "R3"); chk(63, "R3");

        // R4: paired writes and the shared toggle
        bus(16'h2005, 1'b0, 8'h11);
        bus(16'h2005, 1'b0, 8'h22);
        chk(5, "R4"); chk(8, "R4");
        bus(16'h2005, 1'b0, 8'h33);
        bus(16'h3FFE, 1'b0, 8'h44);
        chk(5, "R4"); chk(9, "R4"); chk(6, "R4");

        // R5: status read resets the toggle
        bus(16'h2006, 1'b0, 8'h55);
        bus(16'h2002, 1'b1, 8'hA5);
        bus(16'h2006, 1'b0, 8'h66);
        chk(6, "R5"); chk(9, "R5"); chk(2, "R5");
        bus(16'h2005, 1'b0, 8'h99);
        bus(16'h3A0A, 1'b1, 8'h00);
        bus(16'h2005, 1'b0, 8'h9A);
        chk(5, "R5"); chk(8, "R5");

        // R6: separate read and write slots for the two ports
        bus(16'h4016, 1'b0, 8'h01);
        bus(16'h4016, 1'b1, 8'h41);
        bus(16'h4017, 1'b1, 8'h42);
        bus(16'h4017, 1'b0, 8'hC0);
        chk(54, "R6"); chk(10, "R6"); chk(11, "R6"); chk(55, "R6");

        // R7: reselect and read back
        chk(0, "R7"); chk(63, "R7");

        // R8: ignored accesses
        bus(16'h4020, 1'b0, 8'hEE);
        bus(16'h6000, 1'b0, 8'hEE);
        bus(16'h1FF8, 1'b0, 8'hEE);
        bus(16'h2007, 1'b1, 8'hEE);
        bus(16'h4015, 1'b1, 8'hEE);
        chk(32, "R8"); chk(0, "R8"); chk(7, "R8"); chk(53, "R8"); chk(12, "R8");

        // R9: select traffic between paired writes
        bus(16'h2002, 1'b1, 8'h00);
        bus(16'h2006, 1'b0, 8'hAB);
        chk(6, "R9");
        bus(16'h2006, 1'b0, 8'hCD);
        chk(9, "R9"); chk(6, "R9");

        // R10: last sample before the strobe falls
        bus_late(16'h2003, 8'h5A, 8'hA5);
        chk(3, "R10");

        wait (q.size() == 0);
        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule